// File: doc/BRIEF.md
# Multi-Mode Sample Output Formatter

This block takes one complex sample (an in-phase and a quadrature word) from a down-converter channel and drives it onto an output port. Four output styles are available, chosen by a two-bit field: a held word with a handshake strobe for a host processor, a one-bit serial stream, a four-bit nibble stream, and a full-width parallel word. The block makes a serial clock at half the core clock rate. It also makes a frame-sync strobe that marks the first transfer of each word, and a ready strobe for the processor and parallel styles. Each of the three has its own polarity control.

Two 8-bit registers written through a small port hold the settings. The format register holds the polarity bits, tag enable and ready width. The mode register holds the output style, the ready-pin direction, real-only output and I/Q swap. When tagging is on, a caller-supplied 4-bit tag replaces the low bits of every word. A new sample is accepted only while `in_ready` is high. `in_ready` stays low until the last transfer of the current sample has ended.

Top module: `sample_out_fmt`

## Requirements
- R1: After reset the format register reads 0x40, the mode register reads 0x00, `in_ready` is high, `rdy_oe` is low and `fs_o` is low.
- R2: A write with `cfg_addr`=0 sets the format register: bit 0 inverts the serial clock, bit 1 inverts ready, bit 2 inverts frame sync, bit 3 enables tags, bit 4 selects the long ready pulse. A write with `cfg_addr`=1 sets the mode register: bits 1:0 select the style (0 processor, 1 serial, 2 nibble, 3 parallel), bit 2 is master, bit 3 is real-only, bit 4 swaps I and Q. `cfg_rdata` returns the register that `cfg_addr` selects.
- R3: In serial style each word leaves MSB first on `dout[0]`, one bit per serial-clock period of two core cycles. With the clock not inverted, `dout` changes only where `sck_o` rises.
- R4: With the clock-invert bit set, `sck_o` is inverted, so `dout` changes only where `sck_o` falls.
- R5: In nibble style each word leaves on `dout[3:0]` as four nibbles, most significant first, one per serial-clock period.
- R6: In parallel style each word appears whole on `dout` for one serial-clock period (two core cycles), with ready active over that period.
- R7: In processor style each word is held on `dout` while ready is active for 4 core cycles (long bit 0) or 16 core cycles (long bit 1). Two inactive cycles follow before the next word.
- R8: The ready-invert bit acts only in processor and parallel styles. In serial and nibble styles `rdy_o` stays low.
- R9: Frame sync is active during exactly the first transfer of each word and inactive at all other times, inverted when its invert bit is set.
- R10: With tags enabled, bits 3:0 of every word carry `in_tag`. The upper bits carry the sample.
- R11: A sample is sent as I then Q, or Q then I when the swap bit is set. With real-only set, only I is sent and the swap bit has no effect.
- R12: `rdy_oe` equals the master bit, so the ready pin is driven only when master is set.
- R13: The long-ready bit has no effect outside processor style. Serial transfers keep their two-cycle period.
- R14: `in_ready` falls on the edge that accepts a sample and rises again only after that sample's last transfer has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 format, 1 mode |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | Formatter can take a sample |
| in_i | input | WORD_W | In-phase word |
| in_q | input | WORD_W | Quadrature word |
| in_tag | input | TAG_W | Tag placed in the word LSBs |
| sck_o | output | 1 | Serial clock, half the core rate |
| fs_o | output | 1 | Frame-sync strobe |
| rdy_o | output | 1 | Ready strobe |
| rdy_oe | output | 1 | Ready pin drive enable |
| dout | output | WORD_W | Output data |

## Verification
A fault in the slot counter or word pointer appears at the ports within one sample. The bench rebuilds every word from the captured transfers, so a shifted bit, a missing nibble or a wrong order fails the compare right after that frame ends. A wrong period or pulse-length counter changes the spacing between transfers or the ready length in core cycles, which the bench measures directly. Polarity faults show up in the idle level of each strobe before any sample is sent.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    typedef enum logic [1:0] {
        OM_UP  = 2'd0,
        OM_SER = 2'd1,
        OM_NIB = 2'd2,
        OM_PAR = 2'd3
    } omode_e;

    // format register, bit 0 at the bottom
    typedef struct packed {
        logic [2:0] spare;
        logic       rdy_long;
        logic       tag_en;
        logic       fs_inv;
        logic       rdy_inv;
        logic       sck_inv;
    } fmt_t;

    // mode register
    typedef struct packed {
        logic [2:0] spare;
        logic       swap_iq;
        logic       real_only;
        logic       master;
        omode_e     mode;
    } mcfg_t;

    localparam logic [7:0] FMT_RST = 8'h40;

endpackage

// File: rtl/ofmt_cfg.sv
module ofmt_cfg
    import ofmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       addr,
    input  logic [7:0] wdata,
    output fmt_t       fmt,
    output mcfg_t      mcfg
);

    typedef struct packed {
        fmt_t  fmt;
        mcfg_t mc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr) r_d.mc  = mcfg_t'(wdata);
            else      r_d.fmt = fmt_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.fmt <= fmt_t'(FMT_RST);
            r_q.mc  <= mcfg_t'(8'h00);
        end else begin
            r_q <= r_d;
        end
    end

    assign fmt  = r_q.fmt;
    assign mcfg = r_q.mc;

endmodule

// File: rtl/ofmt_wordsel.sv
module ofmt_wordsel #(
    parameter int WORD_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic [WORD_W-1:0] smp_i,
    input  logic [WORD_W-1:0] smp_q,
    input  logic [TAG_W-1:0]  tag,
    input  logic              tag_en,
    input  logic              swap_iq,
    input  logic              real_only,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1,
    output logic              two
);

    localparam int NWORD = 2;

    logic [WORD_W-1:0] raw   [NWORD];
    logic [WORD_W-1:0] fixed [NWORD];

    // real-only output always leads with I, whatever the swap bit says
    assign raw[0] = (swap_iq && !real_only) ? smp_q : smp_i;
    assign raw[1] = swap_iq ? smp_i : smp_q;

    for (genvar g = 0; g < NWORD; g++) begin : g_tag
        assign fixed[g] = tag_en ? {raw[g][WORD_W-1:TAG_W], tag} : raw[g];
    end

    assign w0  = fixed[0];
    assign w1  = fixed[1];
    assign two = !real_only;

endmodule

// File: rtl/ofmt_seq.sv
module ofmt_seq
    import ofmt_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int UP_SHORT = 4,
    parameter int UP_LONG  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  omode_e            mode,
    input  logic              rdy_long,
    input  logic              load,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic              two,
    output logic              busy,
    output logic              ph,
    output logic              fs_act,
    output logic              rdy_act,
    output logic [WORD_W-1:0] dout
);

    localparam int NIB_W  = 4;
    localparam int SLOT_W = $clog2(WORD_W);
    localparam int CNT_W  = $clog2(UP_LONG + 2);

    typedef struct packed {
        logic              ph;
        logic              busy;
        logic              fin;
        logic              wsel;
        logic              two;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] dout;
        logic              fs;
        logic              rdy;
    } st_t;

    st_t s_d, s_q;

    logic              is_up;
    logic              has_rdy;
    logic [SLOT_W-1:0] last_slot;
    logic [CNT_W-1:0]  first_cnt;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] shifted;

    // per-mode slot geometry
    always_comb begin
        is_up   = (mode == OM_UP);
        has_rdy = is_up || (mode == OM_PAR);
        case (mode)
            OM_SER:  last_slot = SLOT_W'(WORD_W - 1);
            OM_NIB:  last_slot = SLOT_W'(WORD_W / NIB_W - 1);
            default: last_slot = '0;
        endcase
        // a processor slot is the pulse plus two quiet cycles; others are one sck period
        if (is_up) first_cnt = rdy_long ? CNT_W'(UP_LONG + 1) : CNT_W'(UP_SHORT + 1);
        else       first_cnt = CNT_W'(1);
        cur = s_q.wsel ? s_q.w1 : s_q.w0;
        if (mode == OM_NIB) shifted = cur << (NIB_W * int'(s_q.slot));
        else                shifted = cur << s_q.slot;
    end

    always_comb begin
        s_d    = s_q;
        s_d.ph = ~s_q.ph;
        if (s_q.busy) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (is_up && s_q.cnt == CNT_W'(2)) s_d.rdy = 1'b0;
            end else if (!s_q.ph) begin
                // this edge raises the internal sck: a slot boundary
                if (s_q.fin) begin
                    s_d.busy = 1'b0;
                    s_d.fin  = 1'b0;
                    s_d.fs   = 1'b0;
                    s_d.rdy  = 1'b0;
                end else begin
                    case (mode)
                        OM_SER:  s_d.dout = {{(WORD_W-1){1'b0}}, shifted[WORD_W-1]};
                        OM_NIB:  s_d.dout = {{(WORD_W-NIB_W){1'b0}}, shifted[WORD_W-1 -: NIB_W]};
                        default: s_d.dout = cur;
                    endcase
                    s_d.fs  = (s_q.slot == '0);
                    s_d.rdy = has_rdy;
                    s_d.cnt = first_cnt;
                    if (s_q.slot == last_slot) begin
                        s_d.slot = '0;
                        if (s_q.wsel || !s_q.two) s_d.fin  = 1'b1;
                        else                      s_d.wsel = 1'b1;
                    end else begin
                        s_d.slot = s_q.slot + 1'b1;
                    end
                end
            end
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.fin  = 1'b0;
            s_d.wsel = 1'b0;
            s_d.slot = '0;
            s_d.cnt  = '0;
            s_d.w0   = w0;
            s_d.w1   = w1;
            s_d.two  = two;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign ph      = s_q.ph;
    assign fs_act  = s_q.fs;
    assign rdy_act = s_q.rdy;
    assign dout    = s_q.dout;

endmodule

// File: rtl/sample_out_fmt.sv
module sample_out_fmt
    import ofmt_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_i,
    input  logic [WORD_W-1:0] in_q,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              sck_o,
    output logic              fs_o,
    output logic              rdy_o,
    output logic              rdy_oe,
    output logic [WORD_W-1:0] dout
);

    fmt_t              fmt_q;
    mcfg_t             mcfg_q;
    logic [WORD_W-1:0] w0, w1;
    logic              two;
    logic              busy, ph, fs_act, rdy_act;
    logic              rdy_inv_eff;

    ofmt_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .fmt   (fmt_q),
        .mcfg  (mcfg_q)
    );

    ofmt_wordsel #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_sel (
        .smp_i     (in_i),
        .smp_q     (in_q),
        .tag       (in_tag),
        .tag_en    (fmt_q.tag_en),
        .swap_iq   (mcfg_q.swap_iq),
        .real_only (mcfg_q.real_only),
        .w0        (w0),
        .w1        (w1),
        .two       (two)
    );

    ofmt_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mcfg_q.mode),
        .rdy_long (fmt_q.rdy_long),
        .load     (in_valid && !busy),
        .w0       (w0),
        .w1       (w1),
        .two      (two),
        .busy     (busy),
        .ph       (ph),
        .fs_act   (fs_act),
        .rdy_act  (rdy_act),
        .dout     (dout)
    );

    assign rdy_inv_eff = fmt_q.rdy_inv && (mcfg_q.mode == OM_UP || mcfg_q.mode == OM_PAR);

    assign cfg_rdata = cfg_addr ? mcfg_q : fmt_q;
    assign in_ready  = !busy;
    assign sck_o     = ph ^ fmt_q.sck_inv;
    assign fs_o      = fs_act ^ fmt_q.fs_inv;
    assign rdy_o     = rdy_act ^ rdy_inv_eff;
    assign rdy_oe    = mcfg_q.master;

endmodule

// File: rtl/ofmt_chk.sv
module ofmt_chk
    import ofmt_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int TAG_W    = 4,
    parameter int UP_SHORT = 4,
    parameter int UP_LONG  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [TAG_W-1:0]  in_tag,
    input logic [WORD_W-1:0] dout,
    input logic              sck_o,
    input logic              fs_o,
    input logic              rdy_o,
    input logic              sck_inv,
    input logic              fs_inv,
    input logic              rdy_inv,
    input logic              tag_en,
    input logic              rdy_long,
    input omode_e            mode
);

    localparam int RUN_W = $clog2(UP_LONG + 2) + 1;

    logic             rdy_eff;
    logic             up_or_par;
    logic [TAG_W-1:0] tag_q;
    logic [RUN_W-1:0] run_q;
    logic             rdy_prev_q;

    assign up_or_par = (mode == OM_UP) || (mode == OM_PAR);
    assign rdy_eff   = rdy_o ^ (rdy_inv && up_or_par);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q      <= '0;
            run_q      <= '0;
            rdy_prev_q <= 1'b0;
        end else begin
            if (in_valid && in_ready) tag_q <= in_tag;
            if (!rdy_eff)                    run_q <= '0;
            else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
            rdy_prev_q <= rdy_eff;
        end
    end

    AST_DOUT_ON_SCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (sck_o ^ sck_inv)); // R3

    AST_READY_QUIET_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_SER || mode == OM_NIB) |-> !rdy_o); // R8

    AST_ACCEPT_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R14

    AST_UP_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_UP && rdy_prev_q && !rdy_eff) |->
            (run_q == (rdy_long ? RUN_W'(UP_LONG) : RUN_W'(UP_SHORT)))); // R7

    AST_TAG_IN_LSBS: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en && rdy_eff && up_or_par) |-> (dout[TAG_W-1:0] == tag_q)); // R10

    AST_FS_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o ^ fs_inv) |-> !in_ready); // R9

endmodule

bind sample_out_fmt ofmt_chk #(.WORD_W(WORD_W), .TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_tag   (in_tag),
    .dout     (dout),
    .sck_o    (sck_o),
    .fs_o     (fs_o),
    .rdy_o    (rdy_o),
    .sck_inv  (fmt_q.sck_inv),
    .fs_inv   (fmt_q.fs_inv),
    .rdy_inv  (fmt_q.rdy_inv),
    .tag_en   (fmt_q.tag_en),
    .rdy_long (fmt_q.rdy_long),
    .mode     (mcfg_q.mode)
);

// File: tb/sim_sample_out_fmt.sv
`timescale 1ns/1ps
module sim_sample_out_fmt;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic         cfg_addr = 1'b0;
    logic [7:0]   cfg_wdata = '0;
    logic [7:0]   cfg_rdata;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic [3:0]   in_tag = '0;
    logic         sck_o, fs_o, rdy_o, rdy_oe;
    logic [W-1:0] dout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sample_out_fmt #(.WORD_W(W), .TAG_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .in_tag(in_tag),
        .sck_o(sck_o), .fs_o(fs_o), .rdy_o(rdy_o), .rdy_oe(rdy_oe), .dout(dout)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // programs both registers, sends one sample, rebuilds the words from the port
    task automatic run_case(input string rq, input logic [7:0] fv, input logic [7:0] mv,
                            input logic [W-1:0] si, input logic [W-1:0] sq, input logic [3:0] tg);
        logic [1:0] md = mv[1:0];
        bit sinv = fv[0], rinv = fv[1], finv = fv[2], ten = fv[3], rlong = fv[4];
        bit master = mv[2], realo = mv[3], swap = mv[4];
        bit rinv_eff = rinv && (md == 2'd0 || md == 2'd3);
        int nw = realo ? 1 : 2;
        int s_per = (md == 2'd1) ? W : (md == 2'd2) ? W/4 : 1;
        int plen = rlong ? 16 : 4;
        int gap = (md == 2'd0) ? plen + 2 : 2;
        logic [W-1:0] e [2];
        logic [W-1:0] sd [64];
        bit sf [64];
        int n = 0, cyc = 0, last_cyc = 0, rdy_cnt = 0, rdy_hi = 0;
        int gap_bad = 0, stab_bad = 0, fs_bad = 0;
        bit prev_raw, prev_rdy, raw, ra, start;
        logic [W-1:0] last_d;

        e[0] = (swap && !realo) ? sq : si;
        e[1] = swap ? si : sq;
        if (ten) begin e[0][3:0] = tg; e[1][3:0] = tg; end

        cfg_write(1'b0, fv);
        cfg_write(1'b1, mv);
        cfg_addr = 1'b1; #1;
        chk(cfg_rdata == mv, {"R2 mode readback ", rq}, cfg_rdata, mv);
        cfg_addr = 1'b0; #1;
        chk(cfg_rdata == fv, {"R2 format readback ", rq}, cfg_rdata, fv);
        chk(fs_o == finv, {"R9 idle frame-sync level ", rq}, fs_o, finv);
        chk(rdy_o == rinv_eff, {"R8 idle ready level ", rq}, rdy_o, rinv_eff);
        chk(rdy_oe == master, {"R12 ready drive ", rq}, rdy_oe, master);

        @(negedge clk);
        in_valid = 1'b1; in_i = si; in_q = sq; in_tag = tg;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, {"R14 input closed after accept ", rq}, in_ready, 0);

        prev_raw = sck_o ^ sinv;
        prev_rdy = rdy_o ^ rinv_eff;
        last_d = dout;
        while (1) begin
            @(negedge clk);
            cyc++;
            raw = sck_o ^ sinv;
            ra  = rdy_o ^ rinv_eff;
            start = (md == 2'd0) ? (ra && !prev_rdy) : (raw && !prev_raw && !in_ready);
            if (start) begin
                if (n > 0 && cyc - last_cyc != gap) gap_bad++;
                if (n < 64) begin sd[n] = dout; sf[n] = fs_o ^ finv; end
                n++;
                last_cyc = cyc;
            end else if (dout !== last_d) begin
                stab_bad++;
            end
            if (ra) rdy_cnt++;
            if (rdy_o) rdy_hi++;
            last_d = dout; prev_raw = raw; prev_rdy = ra;
            if (in_ready) break;
            if (cyc > 2000) begin
                chk(1'b0, {"R14 frame never ended ", rq}, cyc, 0);
                break;
            end
        end

        chk(n == nw * s_per, {"R11 transfer count ", rq}, n, nw * s_per);
        chk(gap_bad == 0, {"R13 transfer spacing ", rq}, gap_bad, 0);
        chk(stab_bad == 0, sinv ? {"R4 data moves on falling sck ", rq}
                                : {"R3 data moves on rising sck ", rq}, stab_bad, 0);
        if (n == nw * s_per) begin
            for (int j = 0; j < n; j++)
                if (sf[j] != ((j % s_per) == 0)) fs_bad++;
            chk(fs_bad == 0, {"R9 frame-sync placement ", rq}, fs_bad, 0);
            for (int k = 0; k < nw; k++) begin
                logic [W-1:0] v = '0;
                for (int j = 0; j < s_per; j++) begin
                    logic [W-1:0] d = sd[k*s_per + j];
                    case (md)
                        2'd1:    v = {v[W-2:0], d[0]};
                        2'd2:    v = {v[W-5:0], d[3:0]};
                        default: v = d;
                    endcase
                end
                chk(v == e[k], {"R10 R11 word ", rq}, v, e[k]);
            end
        end
        if (md == 2'd0)      chk(rdy_cnt == nw * plen, {"R7 ready length ", rq}, rdy_cnt, nw * plen);
        else if (md == 2'd3) chk(rdy_cnt == nw * 2, {"R6 ready length ", rq}, rdy_cnt, nw * 2);
        else                 chk(rdy_hi == 0, {"R8 ready quiet ", rq}, rdy_hi, 0);
    endtask

    task automatic t_reset();
        cfg_addr = 1'b0; #1;
        chk(cfg_rdata == 8'h40, "R1 format reset", cfg_rdata, 8'h40);
        cfg_addr = 1'b1; #1;
        chk(cfg_rdata == 8'h00, "R1 mode reset", cfg_rdata, 0);
        cfg_addr = 1'b0;
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(rdy_oe == 1'b0, "R1 rdy_oe", rdy_oe, 0);
        chk(fs_o == 1'b0, "R1 fs_o", fs_o, 0);
    endtask

    task automatic t_up_short();      run_case("R7 up short",           8'h40, 8'h04, 16'h1234, 16'hABCD, 4'h0); endtask
    task automatic t_up_long_inv();   run_case("R7 R8 up long inv",     8'h52, 8'h04, 16'h8001, 16'h7FFE, 4'h0); endtask
    task automatic t_serial();        run_case("R3 serial",             8'h40, 8'h05, 16'hC3A5, 16'h0F1E, 4'h0); endtask
    task automatic t_serial_inv();    run_case("R4 R8 R12 serial inv",  8'h47, 8'h01, 16'h9669, 16'h5AA5, 4'h0); endtask
    task automatic t_nibble_tag();    run_case("R5 R10 nibble tag",     8'h48, 8'h06, 16'hFEDC, 16'h3210, 4'hA); endtask
    task automatic t_par_swap();      run_case("R6 R11 parallel swap",  8'h42, 8'h17, 16'h1111, 16'h2222, 4'h0); endtask
    task automatic t_real_only();     run_case("R11 serial real",       8'h40, 8'h0D, 16'hBEEF, 16'hDEAD, 4'h0); endtask
    task automatic t_real_swap();     run_case("R11 parallel real swap",8'h48, 8'h1F, 16'h4321, 16'h8765, 4'h5); endtask
    task automatic t_long_ignored();  run_case("R13 serial long bit",   8'h50, 8'h05, 16'hA5A5, 16'h0001, 4'h0); endtask
    task automatic t_up_tag();        run_case("R10 up tag",            8'h48, 8'h04, 16'hFFFF, 16'h0000, 4'h6); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_up_short();
        t_up_long_inv();
        t_serial();
        t_serial_inv();
        t_nibble_tag();
        t_par_swap();
        t_real_only();
        t_real_swap();
        t_long_ignored();
        t_up_tag();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R14 watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule